// File: doc/BRIEF.md
# PWM Timebase with Shadowed Period

This block is the time reference of one PWM channel. A prescaler divides the PWM clock by a programmable factor. The slowed ticks drive a 16-bit counter that runs upward from zero to an active period value and then starts again at zero. The block signals two events: the return to zero, and the counter reaching the period. Downstream comparators and waveform generators use the count and these two events.

Software never writes the active period directly. Each configuration write loads a shadow period, a prescale value and an update mode. The shadow value then waits as a pending update until the event chosen by the mode arrives. The mode can select the next clock, the counter's return to zero, an external sync pulse, or whichever of those two comes first. This lets the period change without leaving a clipped or stretched cycle at an unsafe moment.

Top module: `pwmt_timebase`

## Requirements
- R1: While reset is held and right after it, `cnt_o` is 0 and both event outputs are low. The block starts with prescale 0, active and shadow period 255 and update mode 0, so return-to-zero events follow each other every 256 clocks.
- R2: The counter advances once every (prescale + 1) clocks, where the prescale is the 8-bit value of the last write. With active period N, return-to-zero events are spaced (prescale + 1) * (N + 1) clocks apart.
- R3: On each tick the count goes up by one, or it goes to 0 when the count is at or above the active period. `zero_evt_o` is high for exactly one clock, the first clock in which `cnt_o` shows 0 after such a wrap.
- R4: `match_evt_o` is high for exactly one clock per period, even when the prescale holds the count for several clocks. That clock is the first one in which `cnt_o` equals the active period, and `cnt_o` reads the period value there.
- R5: Update mode 0 (`cfg_mode_i` = 2'd0) copies the written period into the active period on the second clock edge after the write is sampled.
- R6: Update mode 1 (2'd1, bit 0 set) copies the pending period to the active period only on a wrap to zero. The period already running finishes with its old length.
- R7: Update mode 2 (2'd2, bit 1 set) copies the pending period only at a `sync_i` pulse. Wraps do not apply it, however many occur.
- R8: Update mode 3 (2'd3) copies the pending period at the first wrap or sync pulse, whichever comes first.
- R9: A second write before the selected event replaces the pending value. After an update is applied, nothing remains pending, so later events leave the active period unchanged.
- R10: A `sync_i` pulse while mode 0 or mode 1 is selected does not change the active period.
- R11: If the count is at or above a newly applied active period, the counter wraps to zero on the next tick instead of running to the end of its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the three configuration fields |
| cfg_prescale_i | input | 8 | Clock divide value minus one |
| cfg_period_i | input | 16 | Period for the shadow register |
| cfg_mode_i | input | 2 | Update mode: bit 0 applies at wrap, bit 1 at sync, 0 at once |
| sync_i | input | 1 | External sync, one-clock pulse synchronous to clk_i |
| cnt_o | output | 16 | Current count |
| zero_evt_o | output | 1 | One-clock pulse when the count returns to zero |
| match_evt_o | output | 1 | One-clock pulse when the count reaches the period |

## Verification
The hardest case to reach is a pending shadow value that must survive several candidate events while its own event has not come yet. Examples are a sync-mode update crossing several wraps, or a wrap-mode update receiving a sync pulse. The stimulus writes the shadow value just after a return-to-zero event, while the count is still small. It then observes at least one full period through the count captured at the match event. Only after that does it fire the event that applies the value. The shrink case is reached a different way: the stimulus waits until a long period has its count in the middle of the range, then applies a much smaller period at once.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int unsigned MODE_W = 2;

  // bit 0: apply at wrap, bit 1: apply at sync, none: apply at once
  typedef enum logic [MODE_W-1:0] {
    UPD_NOW    = 2'd0,
    UPD_WRAP   = 2'd1,
    UPD_SYNC   = 2'd2,
    UPD_EITHER = 2'd3
  } upd_mode_e;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] cnt_q;

  // >= so a smaller divider takes effect without a full roll-over
  assign tick_o = (cnt_q >= div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (we_i) div_q <= div_i;
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwmt_period_shadow.sv
module pwmt_period_shadow
  import pwmt_pkg::*;
#(
  parameter int unsigned             CNT_W      = 16,
  parameter logic [CNT_W-1:0]        RST_PERIOD = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  period_i,
  input  upd_mode_e         mode_i,
  input  logic              wrap_i,
  input  logic              sync_i,
  output logic [CNT_W-1:0]  act_o,
  output logic [CNT_W-1:0]  act_nxt_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [CNT_W-1:0]  shad_q;
  logic [CNT_W-1:0]  act_q;
  upd_mode_e         mode_q;
  logic [MODE_W-1:0] mode_bits;
  logic              pend_q;
  logic              upd;

  assign mode_bits = mode_q;

  always_comb begin
    upd = 1'b0;
    if (pend_q) begin
      if (mode_bits == '0)          upd = 1'b1;
      if (mode_bits[0] && wrap_i)   upd = 1'b1;
      if (mode_bits[1] && sync_i)   upd = 1'b1;
    end
  end

  assign act_nxt_o = upd ? shad_q : act_q;
  assign act_o     = act_q;
  assign mode_o    = mode_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shad_q <= RST_PERIOD;
      act_q  <= RST_PERIOD;
      mode_q <= UPD_NOW;
      pend_q <= 1'b0;
    end else begin
      act_q <= act_nxt_o;
      if (we_i) begin
        shad_q <= period_i;
        mode_q <= mode_i;
        pend_q <= 1'b1;
      end else if (upd) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic [CNT_W-1:0] act_nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             zero_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             zero_q;
  logic             match_q;

  assign wrap_o = tick_i && (cnt_q >= act_i);

  always_comb begin
    cnt_d = cnt_q;
    if (wrap_o)      cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      zero_q  <= wrap_o;
      // compare against the period that is active after this edge
      match_q <= tick_i && (cnt_d == act_nxt_i);
    end
  end

  assign cnt_o   = cnt_q;
  assign zero_o  = zero_q;
  assign match_o = match_q;
endmodule

// File: rtl/pwmt_timebase.sv
module pwmt_timebase
  import pwmt_pkg::*;
#(
  parameter int unsigned      PRE_W      = 8,
  parameter int unsigned      CNT_W      = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [PRE_W-1:0]  cfg_prescale_i,
  input  logic [CNT_W-1:0]  cfg_period_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              sync_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_evt_o,
  output logic              match_evt_o
);
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  act_period;
  logic [CNT_W-1:0]  act_next;
  logic [MODE_W-1:0] upd_mode;

  pwmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .div_i  (cfg_prescale_i),
    .tick_o (tick)
  );

  pwmt_period_shadow #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_shad (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .period_i  (cfg_period_i),
    .mode_i    (upd_mode_e'(cfg_mode_i)),
    .wrap_i    (wrap),
    .sync_i    (sync_i),
    .act_o     (act_period),
    .act_nxt_o (act_next),
    .mode_o    (upd_mode)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .act_i     (act_period),
    .act_nxt_i (act_next),
    .cnt_o     (cnt_o),
    .wrap_o    (wrap),
    .zero_o    (zero_evt_o),
    .match_o   (match_evt_o)
  );
endmodule

// File: rtl/pwmt_timebase_chk.sv
module pwmt_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             zero_i,
  input logic             match_i,
  input logic [CNT_W-1:0] act_i,
  input logic [1:0]       mode_i,
  input logic             wrap_i
);
  // R3
  zero_at_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |-> (cnt_i == '0));

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> (cnt_i == '0 || cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  // R11
  wrap_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |-> $past(cnt_i >= act_i));

  // R4
  match_on_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> (cnt_i == act_i));

  // R6
  wrap_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !wrap_i) |=> $stable(act_i));

  // R7
  sync_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !sync_i) |=> $stable(act_i));
endmodule

bind pwmt_timebase pwmt_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_i),
  .cnt_i   (cnt_o),
  .zero_i  (zero_evt_o),
  .match_i (match_evt_o),
  .act_i   (act_period),
  .mode_i  (upd_mode),
  .wrap_i  (wrap)
);

// File: tb/sim_pwmt_timebase.sv
`timescale 1ns/1ps
module sim_pwmt_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  pre = '0;
  logic [15:0] per = '0;
  logic [1:0]  mode = '0;
  logic        sync = 1'b0;
  logic [15:0] cnt;
  logic        zev;
  logic        mev;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwmt_timebase u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_prescale_i(pre),
    .cfg_period_i(per), .cfg_mode_i(mode), .sync_i(sync),
    .cnt_o(cnt), .zero_evt_o(zev), .match_evt_o(mev)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int p, input int n, input int m);
    @(negedge clk);
    we = 1'b1; pre = p[7:0]; per = n[15:0]; mode = m[1:0];
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
  endtask

  task automatic wait_zero();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (zev) return;
    end
    check(1'b0, "wait_zero timeout", 0, 1);
  endtask

  task automatic wait_match(output int v);
    v = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (mev) begin v = int'(cnt); return; end
    end
    check(1'b0, "wait_match timeout", 0, 1);
  endtask

  // from one zero event to the next: spacing, matched count, match pulses
  task automatic measure(output int gap, output int mval, output int nm);
    gap = 0; mval = -1; nm = 0;
    wait_zero();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      gap++;
      if (mev) begin nm++; mval = int'(cnt); end
      if (zev) return;
    end
    check(1'b0, "measure timeout", 0, 1);
  endtask

  task automatic expect_period(input string req, input int p, input int n);
    int g, mv, nm;
    measure(g, mv, nm);
    check(g == (p + 1) * (n + 1), {req, " gap"}, g, (p + 1) * (n + 1));
    check(mv == n, {req, " match count"}, mv, n);
    check(nm == 1, {req, " match pulses"}, nm, 1);
  endtask

  task automatic t_reset();
    check(cnt == 0 && !zev && !mev, "R1 in reset", int'(cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    check(cnt == 0 && !zev && !mev, "R1 after release", int'(cnt), 0);
    expect_period("R1", 0, 255);
  endtask

  task automatic t_prescale();
    write_cfg(2, 9, 0);
    expect_period("R2", 2, 9);
    write_cfg(0, 10, 0);
    expect_period("R3", 0, 10);
  endtask

  task automatic t_shrink_now();
    int tmo;
    write_cfg(0, 200, 0);
    tmo = 0;
    while (cnt != 100 && tmo < 2000) begin @(negedge clk); tmo++; end
    write_cfg(0, 10, 0);
    @(negedge clk);
    check(!zev, "R5 no early apply", int'(zev), 0);
    @(negedge clk);
    check(zev && cnt == 0, "R11 wrap next tick", int'(zev), 1);
    expect_period("R5", 0, 10);
  endtask

  task automatic t_wrap_mode();
    int v;
    wait_zero();
    write_cfg(0, 4, 1);
    pulse_sync();
    wait_match(v);
    check(v == 10, "R10 sync ignored in mode 1", v, 10);
    check(v == 10, "R6 old period finishes", v, 10);
    expect_period("R6", 0, 4);
  endtask

  task automatic t_sync_mode();
    int v;
    wait_zero();
    write_cfg(0, 6, 2);
    expect_period("R7 wraps ignored", 0, 4);
    expect_period("R7 wraps ignored", 0, 4);
    wait_zero();
    pulse_sync();
    wait_match(v);
    check(v == 6, "R7 applied at sync", v, 6);
    expect_period("R7", 0, 6);
  endtask

  task automatic t_replace();
    int v;
    wait_zero();
    write_cfg(0, 8, 2);
    write_cfg(0, 3, 2);
    expect_period("R9 still old", 0, 6);
    wait_zero();
    pulse_sync();
    wait_match(v);
    check(v == 3, "R9 last write wins", v, 3);
    pulse_sync();
    expect_period("R9 nothing pending", 0, 3);
  endtask

  task automatic t_either();
    int v;
    wait_zero();
    write_cfg(0, 9, 3);
    pulse_sync();
    wait_match(v);
    check(v == 9, "R8 sync first", v, 9);
    wait_zero();
    write_cfg(0, 12, 3);
    wait_match(v);
    check(v == 9, "R8 waits for wrap", v, 9);
    expect_period("R8 wrap first", 0, 12);
  endtask

  task automatic t_now_sync();
    write_cfg(0, 5, 0);
    expect_period("R10 mode 0", 0, 5);
    pulse_sync();
    pulse_sync();
    expect_period("R10 sync ignored in mode 0", 0, 5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_prescale();
        t_shrink_now();
        t_wrap_mode();
        t_sync_mode();
        t_replace();
        t_either();
        t_now_sync();
      end
      begin
        wait (cyc >= 150000);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule